// File: doc/BRIEF.md
# Change-Triggered Probe Trace Recorder

This block records activity on an on-chip bus or any group of internal signals for later inspection. It compares a probe vector with the last value it recorded on every clock. It writes a record to an internal trace memory only when the value differs, so long idle stretches cost no storage. Each record holds the new probe value and the number of clock cycles since the previous record, measured with a 16-bit delta counter.

Software or a debug bus master arms the recorder. Capture starts on the first cycle that an external trigger is high. It runs until the memory fills or a stop request arrives. The master then reads the records one word per address through a simple registered read port. A mode input selects what happens when the gap between two events is too long for the 16-bit counter. With compression off, a time-stamp-only filler record is inserted so that timing stays exact. With compression on, the delta saturates instead, which saves entries but loses exact timing.

Top module: `evtrace_recorder`

## Requirements
- R1: While capturing, a record is written only on a clock edge where the probe differs from the last value recorded. An unchanged probe writes nothing, and its cycles add to the delta of the next record.
- R2: A record word places the probe value in bits [PROBE_W-1:0], the 16-bit delta in bits [PROBE_W+15:PROBE_W] and the filler flag in bit PROBE_W+16. For a change record, the delta is the number of clock edges since the edge that wrote the previous record, and the flag is 0.
- R3: With compressEn high, a gap of 65535 cycles or more between two changes produces a single change record whose delta is 65535.
- R4: With compressEn low, on the 65535th edge after the previous record with no change, a filler record is written. It has flag 1, delta 65535 and the last recorded value. The delta count then restarts from zero.
- R5: A pulse on armStart clears recCount and done. No record is written until trigIn is high. On the first such edge, a record with delta 0 and the current probe value is written at address 0.
- R6: After DEPTH records, capture stops, done goes to 1 and recCount equals DEPTH. Later probe changes leave recCount unchanged.
- R7: A pulse on stopReq during capture ends it without writing, and done stays 0.
- R8: rdData presents the record at rdAddr one cycle after rdEn while the recorder is stopped (idle or done). While it is armed or capturing, the read returns zero.
- R9: After reset, done is 0 and recCount is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| probe | input | PROBE_W | Vector under observation |
| trigIn | input | 1 | External start trigger |
| armStart | input | 1 | Arm pulse; clears the trace |
| stopReq | input | 1 | Ends an armed or running capture |
| compressEn | input | 1 | 1 = saturate long gaps, 0 = insert filler records |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | ADDR_W | Record index to read |
| rdData | output | PROBE_W+17 | Record word, valid one cycle after rdEn |
| done | output | 1 | Memory filled, capture over |
| recCount | output | CNT_W | Records written since arming |

## Verification
A wrong last-value register shows up as missing or extra records, and so as a wrong recCount on the very next probe edge. A wrong delta counter shows up only in the delta field of the following record, which is seen when the trace is read back. Overflow handling is exercised with real 65535-cycle gaps in both modes. A filler record that is misplaced or missing therefore appears in the count and in the contents of the next records. A full-memory fault appears as done rising at the wrong record, or as recCount moving after done.

// File: rtl/evtrace_pkg.sv
package evtrace_pkg;
  localparam int DELTA_W = 16;
  localparam logic [DELTA_W-1:0] DELTA_MAX = '1;

  typedef struct packed {
    logic               wrEn;
    logic               nullEv;
    logic [DELTA_W-1:0] delta;
    logic               clrCount;
    logic               readOk;
  } trace_strobe_t;
endpackage

// File: rtl/evtrace_ctrl.sv
module evtrace_ctrl
  import evtrace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armStart,
  input  logic             stopReq,
  input  logic             trigIn,
  input  logic             compressEn,
  input  logic             changed,
  input  logic [CNT_W-1:0] recCount,
  output trace_strobe_t    strobe,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CAPT, S_DONE} state_t;

  state_t state, stateNext;
  logic [DELTA_W-1:0] cnt, cntNext, deltaNow;
  logic lastSlot;

  assign deltaNow = (cnt == DELTA_MAX) ? DELTA_MAX : cnt + 1'b1;
  assign lastSlot = (recCount == CNT_W'(DEPTH - 1));

  always_comb begin
    strobe = '0;
    strobe.readOk = (state == S_IDLE) || (state == S_DONE);
    stateNext = state;
    cntNext = cnt;
    if (armStart) begin
      stateNext = S_ARMED;
      strobe.clrCount = 1'b1;
      cntNext = '0;
    end else begin
      case (state)
        S_ARMED: begin
          if (stopReq) begin
            stateNext = S_IDLE;
          end else if (trigIn) begin
            strobe.wrEn = 1'b1;
            cntNext = '0;
            stateNext = lastSlot ? S_DONE : S_CAPT;
          end
        end
        S_CAPT: begin
          if (stopReq) begin
            stateNext = S_IDLE;
          end else begin
            if (changed) begin
              strobe.wrEn = 1'b1;
              strobe.delta = deltaNow;
              cntNext = '0;
            end else if (!compressEn && deltaNow == DELTA_MAX) begin
              strobe.wrEn = 1'b1;
              strobe.nullEv = 1'b1;
              strobe.delta = DELTA_MAX;
              cntNext = '0;
            end else begin
              cntNext = deltaNow;
            end
            if (strobe.wrEn && lastSlot) stateNext = S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt <= '0;
    end else begin
      state <= stateNext;
      cnt <= cntNext;
    end
  end

  assign done = (state == S_DONE);

  AST_COUNT_FROZEN_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !armStart) |=> $stable(recCount)); // R6
  AST_NO_WRITE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE || state == S_DONE) |-> !strobe.wrEn); // R7
endmodule

// File: rtl/evtrace_datapath.sv
module evtrace_datapath
  import evtrace_pkg::*;
#(
  parameter int PROBE_W = 32,
  parameter int DEPTH = 64,
  localparam int REC_W = PROBE_W + DELTA_W + 1,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PROBE_W-1:0] probe,
  input  logic               compressEn,
  input  trace_strobe_t      strobe,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               changed,
  output logic [CNT_W-1:0]   recCount,
  output logic [REC_W-1:0]   rdData
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [PROBE_W-1:0] lastVal;
  logic [REC_W-1:0] recWord;

  assign changed = (probe != lastVal);
  assign recWord = {strobe.nullEv, strobe.delta, strobe.nullEv ? lastVal : probe};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[recCount[ADDR_W-1:0]] <= recWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCount <= '0;
      lastVal <= '0;
      rdData <= '0;
    end else begin
      if (strobe.clrCount) recCount <= '0;
      else if (strobe.wrEn) recCount <= recCount + 1'b1;
      if (strobe.wrEn && !strobe.nullEv) lastVal <= probe;
      if (rdEn && strobe.readOk) rdData <= mem[rdAddr];
      else rdData <= '0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (recCount < CNT_W'(DEPTH))); // R6
  AST_CHANGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.nullEv && strobe.delta != '0) |-> changed); // R1
  AST_FILLER_UNCOMPRESSED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.nullEv) |-> (!compressEn && !changed)); // R4
  AST_READ_ZERO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !strobe.readOk) |=> (rdData == '0)); // R8
endmodule

// File: rtl/evtrace_recorder.sv
module evtrace_recorder
  import evtrace_pkg::*;
#(
  parameter int PROBE_W = 32,
  parameter int DEPTH = 64,
  localparam int REC_W = PROBE_W + DELTA_W + 1,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PROBE_W-1:0] probe,
  input  logic               trigIn,
  input  logic               armStart,
  input  logic               stopReq,
  input  logic               compressEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [REC_W-1:0]   rdData,
  output logic               done,
  output logic [CNT_W-1:0]   recCount
);
  generate
    if (!(PROBE_W == 16 || PROBE_W == 32 || PROBE_W == 64 || PROBE_W == 128))
      $error("PROBE_W must be 16, 32, 64 or 128");
  endgenerate

  trace_strobe_t strobe;
  logic changed;

  evtrace_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .armStart(armStart), .stopReq(stopReq),
    .trigIn(trigIn), .compressEn(compressEn), .changed(changed),
    .recCount(recCount), .strobe(strobe), .done(done)
  );

  evtrace_datapath #(.PROBE_W(PROBE_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .probe(probe), .compressEn(compressEn),
    .strobe(strobe), .rdEn(rdEn), .rdAddr(rdAddr), .changed(changed),
    .recCount(recCount), .rdData(rdData)
  );
endmodule

// File: tb/evtrace_recorder_test.sv
module evtrace_recorder_test;
  localparam int PW = 32;
  localparam int DEPTH = 64;
  localparam int REC_W = PW + 17;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NVEC = 8;
  localparam int GAP [NVEC] = '{3, 1, 5, 2, 7, 1, 4, 2};
  localparam logic [PW-1:0] VAL [NVEC] = '{32'h1, 32'hA5, 32'hA5, 32'h0,
                                           32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000, 32'h77};

  logic clk = 0, rstN = 0;
  logic [PW-1:0] probe = '0;
  logic trigIn = 0, armStart = 0, stopReq = 0, compressEn = 0, rdEn = 0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [REC_W-1:0] rdData;
  logic done;
  logic [CNT_W-1:0] recCount;

  int nCmp = 0, nBad = 0;
  bit finished = 0;
  logic [REC_W-1:0] expRec [DEPTH];
  int expN;

  always #5 clk = ~clk;

  evtrace_recorder #(.PROBE_W(PW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .probe(probe), .trigIn(trigIn), .armStart(armStart),
    .stopReq(stopReq), .compressEn(compressEn), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .done(done), .recCount(recCount)
  );

  function automatic logic [REC_W-1:0] mkRec(logic isNull, logic [15:0] d, logic [PW-1:0] v);
    return {isNull, d, v};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readRec(int addr, output logic [REC_W-1:0] r);
    @(negedge clk); rdEn = 1; rdAddr = ADDR_W'(addr);
    @(negedge clk); rdEn = 0; r = rdData;
  endtask

  task automatic pulseArm();
    @(negedge clk); armStart = 1;
    @(negedge clk); armStart = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopReq = 1;
    @(negedge clk); stopReq = 0;
  endtask

  task automatic checkTrace(string req);
    logic [REC_W-1:0] r;
    chk(req, 64'(recCount), 64'(expN));
    for (int i = 0; i < expN; i++) begin
      readRec(i, r);
      chk(req, 64'(r[REC_W-1:PW]), 64'(expRec[i][REC_W-1:PW]));
      chk(req, 64'(r[PW-1:0]), 64'(expRec[i][PW-1:0]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [REC_W-1:0] r;
    logic [PW-1:0] last;
    int acc;
    repeat (3) @(negedge clk);
    chk("R9 done", 64'(done), 0);
    chk("R9 count", 64'(recCount), 0);
    rstN = 1;
    @(negedge clk);
    chk("R9 count after release", 64'(recCount), 0);

    // Table-driven capture, compression off; trigger gating first (R5)
    compressEn = 0;
    pulseArm();
    for (int k = 0; k < 5; k++) begin @(negedge clk); probe = 32'(k * 3 + 7); end
    @(negedge clk);
    chk("R5 no record before trigger", 64'(recCount), 0);
    probe = 32'h1234; trigIn = 1;
    expRec[0] = mkRec(0, 0, 32'h1234); expN = 1;
    last = 32'h1234; acc = 0;
    for (int i = 0; i < NVEC; i++) begin
      repeat (GAP[i]) @(negedge clk);
      probe = VAL[i];
      acc += GAP[i];
      if (VAL[i] != last) begin
        expRec[expN] = mkRec(0, 16'(acc), VAL[i]);
        expN++; acc = 0; last = VAL[i];
      end
    end
    repeat (3) @(negedge clk);
    trigIn = 0;
    rdEn = 1; rdAddr = '0;
    @(negedge clk); rdEn = 0;
    chk("R8 read while capturing is zero", 64'(rdData), 0);
    pulseStop();
    chk("R7 stop leaves done low", 64'(done), 0);
    checkTrace("R1 R2 table trace");

    // Filler record on overflow, compression off (R4)
    pulseArm();
    probe = 32'hC0DE; trigIn = 1;
    @(negedge clk); trigIn = 0;
    repeat (65544) @(negedge clk);
    probe = 32'hBEEF;
    repeat (2) @(negedge clk);
    pulseStop();
    expRec[0] = mkRec(0, 0, 32'hC0DE);
    expRec[1] = mkRec(1, 16'hFFFF, 32'hC0DE);
    expRec[2] = mkRec(0, 16'd10, 32'hBEEF);
    expN = 3;
    checkTrace("R4 filler record");

    // Saturation, compression on (R3)
    compressEn = 1;
    pulseArm();
    probe = 32'h5; trigIn = 1;
    @(negedge clk); trigIn = 0;
    repeat (69999) @(negedge clk);
    probe = 32'h6;
    @(negedge clk);
    expRec[0] = mkRec(0, 0, 32'h5);
    expRec[1] = mkRec(0, 16'hFFFF, 32'h6);
    expN = 2;
    pulseStop();
    checkTrace("R3 saturated delta");
    compressEn = 0;

    // Fill the memory (R6)
    pulseArm();
    probe = 32'hFFFF_0000; trigIn = 1;
    for (int k = 1; k < DEPTH + 6; k++) begin
      @(negedge clk); trigIn = 0; probe = 32'(k);
    end
    @(negedge clk);
    chk("R6 done at full", 64'(done), 1);
    chk("R6 count at full", 64'(recCount), 64'(DEPTH));
    probe = 32'h9999;
    repeat (2) @(negedge clk);
    chk("R6 count frozen", 64'(recCount), 64'(DEPTH));
    readRec(DEPTH - 1, r);
    chk("R6 last record", 64'(r), 64'(mkRec(0, 1, 32'(DEPTH - 1))));
    readRec(0, r);
    chk("R8 read in done", 64'(r), 64'(mkRec(0, 0, 32'hFFFF_0000)));

    // Re-arm clears (R5), armed read returns zero (R8)
    pulseArm();
    chk("R5 done cleared", 64'(done), 0);
    chk("R5 count cleared", 64'(recCount), 0);
    readRec(0, r);
    chk("R8 read while armed is zero", 64'(r), 0);
    chk("R5 still waiting for trigger", 64'(recCount), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule